// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers up to sixteen interrupt requests from peripheral sources into a latched status register. A one-cycle pulse on a request bit sets the matching status bit, and the bit then stays set until software clears it. A second register holds a per-source enable mask. The single CPU interrupt line is high while at least one status bit is set and its mask bit is also set.

Software reaches both registers through a small memory-mapped register port. Writing the status register acknowledges sources by bitwise AND: a 0 in the written word clears that status bit, and a 1 leaves it as it is. Writing the mask register stores the word directly. Bus writes may be 16 or 32 bits wide, and only the low 16 bits are used. The interrupt line follows the register contents, so unmasking a pending source raises it on the next cycle. Status bit 3 is wired to the DMA controller. That assignment is a system convention, and the block treats bit 3 like any other bit.

Top module: `irq_stat_mask`

## Requirements
- R1: After reset, the status register and the mask register both read 0 and irq_o is low.
- R2: A request pulse on req_i[k] sets status bit k at the next clock edge, and the bit stays set after the pulse ends, until it is acknowledged.
- R3: A write to the status register (offset 0x1070) replaces the status register with (status AND wdata_i[15:0]): a 0 bit clears, and a 1 bit leaves the bit unchanged and never sets a clear bit.
- R4: A write to the mask register (offset 0x1074) stores wdata_i[15:0] into the mask register.
- R5: irq_o is high exactly when (status AND mask) is nonzero, one cycle after the edge that updated either register.
- R6: Setting a mask bit for an already pending status bit raises irq_o on the next cycle, and clearing that mask bit drops irq_o, with no change to the status register.
- R7: When req_i[k] is high in the same cycle as a status write that clears bit k, bit k ends up set.
- R8: Bits 31:16 of wdata_i have no effect on either register.
- R9: Reads at 0x1070 and 0x1074 return the register value zero-extended to 32 bits, and reads at any other offset return 0. Writes to other offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data; only bits 15:0 are used |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| req_i | input | 16 | Request pulses, one bit per source |
| irq_o | output | 1 | CPU interrupt line |

## Verification
Requests are applied as a single bit, as two bits together (including the DMA bit 3), and together with an acknowledge. The set-and-hold behaviour is therefore separated from the request-wins priority. Acknowledge words that clear one bit and leave the others set show that the write is an AND and not a plain store. Mask words that toggle the enable of a pending bit show that the interrupt line follows the register contents and not the request pulses. Write words with junk in the upper half, and accesses to neighbouring offsets, show that those bits and those addresses have no effect.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC_DEF  = 16;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned ADDR_W_DEF   = 16;
  localparam logic [15:0] STAT_OFS_DEF = 16'h1070;
  localparam logic [15:0] MASK_OFS_DEF = 16'h1074;
  localparam int unsigned DMA_SRC_BIT  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_STAT = 2'b01,
    SEL_MASK = 2'b10
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = '0,
  parameter logic [ADDR_W-1:0] MASK_OFS = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output irq_pkg::reg_sel_e sel_o
);
  always_comb begin
    if (addr_i == STAT_OFS)      sel_o = irq_pkg::SEL_STAT;
    else if (addr_i == MASK_OFS) sel_o = irq_pkg::SEL_MASK;
    else                         sel_o = irq_pkg::SEL_NONE;
  end
endmodule

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_we_i,
  input  logic ack_keep_i,
  output logic q_o
);
  logic q_d;

  // request beats a same-cycle clear
  always_comb begin
    q_d = q_o;
    if (ack_we_i) q_d = q_o & ack_keep_i;
    if (req_i)    q_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_stat_mask.sv
module irq_stat_mask #(
  parameter int unsigned NUM_SRC  = irq_pkg::NUM_SRC_DEF,
  parameter int unsigned DATA_W   = irq_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W   = irq_pkg::ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] STAT_OFS = irq_pkg::STAT_OFS_DEF,
  parameter logic [ADDR_W-1:0] MASK_OFS = irq_pkg::MASK_OFS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] req_i,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  irq_pkg::reg_sel_e  sel;
  logic               stat_we;
  logic               mask_we;
  logic [NUM_SRC-1:0] wr_lo;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;

  irq_addr_dec #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign stat_we = wr_en_i && (sel == irq_pkg::SEL_STAT);
  assign mask_we = wr_en_i && (sel == irq_pkg::SEL_MASK);
  assign wr_lo   = wdata_i[NUM_SRC-1:0];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_stat
    irq_stat_bit u_bit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[k]),
      .ack_we_i  (stat_we),
      .ack_keep_i(wr_lo[k]),
      .q_o       (stat_q[k])
    );
  end

  irq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mask_we),
    .d_i   (wr_lo),
    .q_o   (mask_q)
  );

  assign irq_o = |(stat_q & mask_q);

  always_comb begin
    unique case (sel)
      irq_pkg::SEL_STAT: rdata_o = {{PAD_W{1'b0}}, stat_q};
      irq_pkg::SEL_MASK: rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_stat_mask_chk.sv
module irq_stat_mask_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = '0,
  parameter logic [ADDR_W-1:0] MASK_OFS = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [NUM_SRC-1:0] wr_lo,
  input logic [NUM_SRC-1:0] req_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q
);
  logic st_wr, mk_wr;
  assign st_wr = wr_en_i && (addr_i == STAT_OFS);
  assign mk_wr = wr_en_i && (addr_i == MASK_OFS);

  AST_REQ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((stat_q & $past(req_i)) == $past(req_i))); // R7

  AST_ACK_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && req_i == '0) |=> (stat_q == ($past(stat_q) & $past(wr_lo)))); // R3

  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_wr && req_i == '0) |=> $stable(stat_q)); // R2

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_wr |=> (mask_q == $past(wr_lo))); // R4

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_wr |=> $stable(mask_q)); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(irq_o) |-> $past(wr_en_i || (|req_i))); // R5
endmodule

bind irq_stat_mask irq_stat_mask_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS),
  .MASK_OFS(MASK_OFS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .wr_lo  (wr_lo),
  .req_i  (req_i),
  .irq_o  (irq_o),
  .stat_q (stat_q),
  .mask_q (mask_q)
);

// File: tb/irq_stat_mask_test.sv
module irq_stat_mask_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_STAT = 16'h1070;
  localparam logic [15:0] A_MASK = 16'h1074;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] req_i = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_stat_mask uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .req_i(req_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, registers update at the following posedge
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [15:0] rq);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; req_i = rq;
    @(negedge clk_i);
    wr_en_i = 1'b0; req_i = '0; wdata_i = '0;
  endtask

  task automatic pulse(input logic [15:0] rq);
    @(negedge clk_i);
    req_i = rq;
    @(negedge clk_i);
    req_i = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_MASK, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    pulse(16'h0009);
    repeat (2) @(negedge clk_i);
    rd(A_STAT, v); chk("R2 held bits", v, 32'h0000_0009);
    chk("R5 masked irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_mask_unmask();
    logic [31:0] v;
    wr(A_MASK, 32'hABCD_0008, '0);
    rd(A_MASK, v); chk("R8 mask upper ignored", v, 32'h0000_0008);
    chk("R6 unmask irq", {31'b0, irq_o}, 32'h1);
    wr(A_MASK, 32'h0000_0002, '0);
    rd(A_MASK, v); chk("R4 mask store", v, 32'h0000_0002);
    chk("R6 remask irq", {31'b0, irq_o}, 32'h0);
    rd(A_STAT, v); chk("R6 status kept", v, 32'h0000_0009);
  endtask

  task automatic t_partial_ack();
    logic [31:0] v;
    wr(A_STAT, 32'h0000_FFF7, '0);
    rd(A_STAT, v); chk("R3 clear bit3", v, 32'h0000_0001);
    wr(A_STAT, 32'hFFFE_FFFF, '0);
    rd(A_STAT, v); chk("R3 ones keep", v, 32'h0000_0001);
    wr(A_STAT, 32'h0001_FFFE, '0);
    rd(A_STAT, v); chk("R8 status upper ignored", v, 32'h0000_0000);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    pulse(16'h0041);
    wr(A_MASK, 32'h0000_0020, '0);
    chk("R5 no match irq", {31'b0, irq_o}, 32'h0);
    wr(A_STAT, 32'h0000_0000, 16'h0020);
    rd(A_STAT, v); chk("R7 request wins", v, 32'h0000_0020);
    chk("R5 irq on match", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0000_0000, '0);
    rd(A_STAT, v); chk("R3 full ack", v, 32'h0);
    chk("R5 irq after ack", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_other_addr();
    logic [31:0] v;
    pulse(16'h8000);
    wr(16'h1072, 32'h0, '0);
    wr(16'h1078, 32'h0000_FFFF, '0);
    rd(A_STAT, v); chk("R9 stray write status", v, 32'h0000_8000);
    rd(A_MASK, v); chk("R9 stray write mask", v, 32'h0000_0020);
    rd(16'h1078, v); chk("R9 unmapped read", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_set();
    t_mask_unmask();
    t_partial_ack();
    t_simul();
    t_other_addr();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule